// File: doc/BRIEF.md
# Time-Multiplexed Latency-Insensitive Port

This block is a point-to-point FIFO port between two modules of a cycle-level model. Each of the two modules steps through N virtual instances in round-robin order. The port models a fixed latency of L model cycles. The producer writes one token per instance per model cycle. A token is either a message, which carries a payload, or a no-message marker, which carries none. Both kinds take up one slot. The consumer reads tokens back in the same order.

At reset the port already holds N×L no-message tokens. The consumer's first N×L reads therefore see the empty latency window, and the two sides can work on different instances and different model cycles at the same time. The buffer has N×L plus a parameterised number of spare slots, and at least one spare slot is required.

The surrounding modules use two flags to resynchronise without a central controller. The light flag means the port holds fewer tokens than N×L. The heavy flag means it holds more. A module may advance when one of its input ports is heavy or one of its output ports is light.

Top module: `tmux_li_port`

## Requirements
- R1: After reset the port holds N×L tokens. cons_not_empty is 1, prod_not_full is 1, and port_light and port_heavy are both 0.
- R2: The first N×L tokens read after reset are no-message tokens: cons_msg_vld is 0 and cons_msg_data is 0.
- R3: Tokens leave in the order they were written, and each keeps its message bit and payload.
- R4: The capacity is N×L+EXTRA_SLOTS tokens. prod_not_full is 0 exactly when that many are held, and a push while full is dropped without changing contents.
- R5: A pop while empty is ignored. When the port is empty, cons_not_empty, cons_msg_vld and cons_msg_data are all 0.
- R6: When a push and a pop are both accepted in the same cycle, the occupancy and every status flag stay unchanged.
- R7: port_light is 1 exactly when occupancy is below N×L, and port_heavy is 1 exactly when occupancy is above N×L.
- R8: A pushed no-message token (prod_msg_vld=0) occupies a slot like a message and comes out with cons_msg_vld=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; preloads the latency window |
| prod_push | input | 1 | Write one token this cycle |
| prod_msg_vld | input | 1 | 1: token carries a message, 0: no-message token |
| prod_msg_data | input | PAYLOAD_W | Message payload |
| prod_not_full | output | 1 | A slot is free |
| cons_pop | input | 1 | Remove the head token this cycle |
| cons_msg_vld | output | 1 | Head token carries a message |
| cons_msg_data | output | PAYLOAD_W | Head payload, 0 when empty |
| cons_not_empty | output | 1 | At least one token is held |
| port_light | output | 1 | Occupancy below N×L |
| port_heavy | output | 1 | Occupancy above N×L |

## Verification
The bench drains the preload window first. A port without the preload, or with a preload of the wrong size, would show a real message too early or run empty too soon.

It then fills the port to capacity and keeps pushing. A wrong capacity or a missing full gate would move the point where the not-full flag drops, or would overwrite unread tokens.

Pops on an empty port check for underflow, which would wrap the counter and raise a false heavy flag. Long runs of simultaneous push and pop, with random traffic mixed in, catch a counter that moves when it should hold and light or heavy thresholds that are off by one.

// File: rtl/tmport_pkg.sv
package tmport_pkg;

   typedef enum logic [1:0] {
      OCC_LIGHT   = 2'd0,
      OCC_NOMINAL = 2'd1,
      OCC_HEAVY   = 2'd2
   } occ_level_e;

endpackage

// File: rtl/tmport_ring_ptr.sv
module tmport_ring_ptr #(
   parameter int DEPTH   = 9,
   parameter int PTR_W   = 4,
   parameter int RST_VAL = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [PTR_W-1:0] ptr
);
   localparam logic [PTR_W-1:0] LAST  = PTR_W'(DEPTH - 1);
   localparam logic [PTR_W-1:0] START = PTR_W'(RST_VAL);

   logic [PTR_W-1:0] nxt;

   generate
      if ((1 << PTR_W) == DEPTH) begin : g_pow2
         always_comb nxt = ptr + 1'b1;
      end else begin : g_wrap
         always_comb nxt = (ptr == LAST) ? '0 : ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)   ptr <= START;
      else if (adv) ptr <= nxt;
   end

   assert_ptr_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= LAST);
endmodule

// File: rtl/tmport_store.sv
module tmport_store #(
   parameter int DEPTH     = 9,
   parameter int PTR_W     = 4,
   parameter int PAYLOAD_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [PTR_W-1:0]     wr_ptr,
   input  logic                 wr_msg,
   input  logic [PAYLOAD_W-1:0] wr_data,
   input  logic [PTR_W-1:0]     rd_ptr,
   output logic                 rd_msg,
   output logic [PAYLOAD_W-1:0] rd_data
);
   logic                 ent_msg  [DEPTH];
   logic [PAYLOAD_W-1:0] ent_data [DEPTH];

   // Reset clears every slot: the preloaded window is all no-message tokens.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            ent_msg[i]  <= 1'b0;
            ent_data[i] <= '0;
         end
      end else if (wr_en) begin
         ent_msg[wr_ptr]  <= wr_msg;
         ent_data[wr_ptr] <= wr_data;
      end
   end

   always_comb begin
      rd_msg  = ent_msg[rd_ptr];
      rd_data = ent_data[rd_ptr];
   end
endmodule

// File: rtl/tmport_occupancy.sv
module tmport_occupancy
   import tmport_pkg::*;
#(
   parameter int DEPTH   = 9,
   parameter int NOMINAL = 8,
   parameter int CNT_W   = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       inc,
   input  logic       dec,
   output logic       not_full,
   output logic       not_empty,
   output occ_level_e level
);
   localparam logic [CNT_W-1:0] CAP_C = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] NOM_C = CNT_W'(NOMINAL);

   logic [CNT_W-1:0] count;

   always_ff @(posedge clk) begin
      if (!rst_n) count <= NOM_C;
      else if (inc && !dec) count <= count + 1'b1;
      else if (dec && !inc) count <= count - 1'b1;
   end

   always_comb begin
      not_full  = (count != CAP_C);
      not_empty = (count != '0);
      if (count < NOM_C)      level = OCC_LIGHT;
      else if (count > NOM_C) level = OCC_HEAVY;
      else                    level = OCC_NOMINAL;
   end

   assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(inc && !dec && count == CAP_C));
   assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(dec && count == '0));
   assert_hold_on_both_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && dec) |=> $stable(count));
endmodule

// File: rtl/tmux_li_port.sv
module tmux_li_port
   import tmport_pkg::*;
#(
   parameter int INSTANCES   = 4,
   parameter int LATENCY     = 2,
   parameter int EXTRA_SLOTS = 1,
   parameter int PAYLOAD_W   = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 prod_push,
   input  logic                 prod_msg_vld,
   input  logic [PAYLOAD_W-1:0] prod_msg_data,
   output logic                 prod_not_full,
   input  logic                 cons_pop,
   output logic                 cons_msg_vld,
   output logic [PAYLOAD_W-1:0] cons_msg_data,
   output logic                 cons_not_empty,
   output logic                 port_light,
   output logic                 port_heavy
);
   localparam int NOMINAL = INSTANCES * LATENCY;
   localparam int DEPTH   = NOMINAL + EXTRA_SLOTS;
   localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W   = $clog2(DEPTH + 1);

   generate
      if (INSTANCES < 1) begin : g_bad_inst
         $error("tmux_li_port: INSTANCES must be at least 1");
      end
      if (LATENCY < 1) begin : g_bad_lat
         $error("tmux_li_port: LATENCY must be at least 1");
      end
      if (EXTRA_SLOTS < 1) begin : g_bad_extra
         $error("tmux_li_port: EXTRA_SLOTS must be at least 1");
      end
      if (PAYLOAD_W < 1) begin : g_bad_w
         $error("tmux_li_port: PAYLOAD_W must be at least 1");
      end
   endgenerate

   logic                 push_ok, pop_ok;
   logic                 nf, ne;
   occ_level_e           lvl;
   logic [PTR_W-1:0]     wr_ptr, rd_ptr;
   logic                 head_msg;
   logic [PAYLOAD_W-1:0] head_data;

   always_comb begin
      push_ok = prod_push && nf;
      pop_ok  = cons_pop && ne;
   end

   tmport_occupancy #(.DEPTH(DEPTH), .NOMINAL(NOMINAL), .CNT_W(CNT_W)) u_occ (
      .clk(clk), .rst_n(rst_n), .inc(push_ok), .dec(pop_ok),
      .not_full(nf), .not_empty(ne), .level(lvl)
   );

   tmport_ring_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W), .RST_VAL(NOMINAL)) u_wr_ptr (
      .clk(clk), .rst_n(rst_n), .adv(push_ok), .ptr(wr_ptr)
   );

   tmport_ring_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W), .RST_VAL(0)) u_rd_ptr (
      .clk(clk), .rst_n(rst_n), .adv(pop_ok), .ptr(rd_ptr)
   );

   tmport_store #(.DEPTH(DEPTH), .PTR_W(PTR_W), .PAYLOAD_W(PAYLOAD_W)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(push_ok), .wr_ptr(wr_ptr),
      .wr_msg(prod_msg_vld), .wr_data(prod_msg_data),
      .rd_ptr(rd_ptr), .rd_msg(head_msg), .rd_data(head_data)
   );

   always_comb begin
      prod_not_full  = nf;
      cons_not_empty = ne;
      cons_msg_vld   = ne && head_msg;
      cons_msg_data  = ne ? head_data : '0;
      port_light     = (lvl == OCC_LIGHT);
      port_heavy     = (lvl == OCC_HEAVY);
   end

   assert_heavy_has_tokens_R7: assert property (@(posedge clk) disable iff (!rst_n)
      port_heavy |-> cons_not_empty);
   assert_light_has_room_R7: assert property (@(posedge clk) disable iff (!rst_n)
      port_light |-> prod_not_full);
   assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({port_light, port_heavy}));
   assert_empty_no_msg_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !cons_not_empty |-> !cons_msg_vld);
   assert_ptrs_meet_when_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!prod_not_full || !cons_not_empty) |-> (wr_ptr == rd_ptr));
endmodule

// File: tb/tmux_li_port_test.sv
module tmux_li_port_test;
   localparam int CLK_P = 10;
   localparam int NI    = 4;
   localparam int LT    = 2;
   localparam int EX    = 1;
   localparam int PW    = 8;
   localparam int NL    = NI * LT;
   localparam int CAP   = NL + EX;

   logic          clk = 0;
   logic          rst_n = 0;
   logic          prod_push = 0, prod_msg_vld = 0, cons_pop = 0;
   logic [PW-1:0] prod_msg_data = '0;
   logic          prod_not_full, cons_msg_vld, cons_not_empty, port_light, port_heavy;
   logic [PW-1:0] cons_msg_data;

   int checks = 0;
   int failures = 0;

   logic [PW:0] q[$];
   int          preload_left;
   bit          r6_pending = 0;
   logic [3:0]  r6_flags;

   always #(CLK_P/2) clk = ~clk;

   tmux_li_port #(.INSTANCES(NI), .LATENCY(LT), .EXTRA_SLOTS(EX), .PAYLOAD_W(PW)) uut (
      .clk(clk), .rst_n(rst_n),
      .prod_push(prod_push), .prod_msg_vld(prod_msg_vld), .prod_msg_data(prod_msg_data),
      .prod_not_full(prod_not_full),
      .cons_pop(cons_pop), .cons_msg_vld(cons_msg_vld), .cons_msg_data(cons_msg_data),
      .cons_not_empty(cons_not_empty), .port_light(port_light), .port_heavy(port_heavy)
   );

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare();
      int sz = q.size();
      string ht;
      chk(cons_not_empty == (sz > 0), "R5", "cons_not_empty", cons_not_empty, sz > 0);
      chk(prod_not_full == (sz < CAP), "R4", "prod_not_full", prod_not_full, sz < CAP);
      chk(port_light == (sz < NL), "R7", "port_light", port_light, sz < NL);
      chk(port_heavy == (sz > NL), "R7", "port_heavy", port_heavy, sz > NL);
      if (sz == 0) begin
         chk(cons_msg_vld == 1'b0, "R5", "empty msg_vld", cons_msg_vld, 0);
         chk(cons_msg_data == '0, "R5", "empty data", cons_msg_data, 0);
      end else begin
         if (preload_left > 0) ht = "R2";
         else if (!q[0][PW]) ht = "R8";
         else ht = "R3";
         chk(cons_msg_vld == q[0][PW], ht, "head msg_vld", cons_msg_vld, q[0][PW]);
         chk(cons_msg_data == q[0][PW-1:0], ht, "head data", cons_msg_data, q[0][PW-1:0]);
      end
      if (r6_pending) begin
         chk({prod_not_full, cons_not_empty, port_light, port_heavy} == r6_flags, "R6",
             "flags after push+pop", {prod_not_full, cons_not_empty, port_light, port_heavy}, r6_flags);
         r6_pending = 0;
      end
   endtask

   task automatic step(input logic push, input logic msg, input logic [PW-1:0] dat, input logic pop);
      bit acc_push, acc_pop;
      @(negedge clk);
      compare();
      prod_push = push; prod_msg_vld = msg; prod_msg_data = dat; cons_pop = pop;
      acc_push = push && (q.size() < CAP);
      acc_pop  = pop && (q.size() > 0);
      if (acc_push && acc_pop) begin
         r6_pending = 1;
         r6_flags = {prod_not_full, cons_not_empty, port_light, port_heavy};
      end
      @(posedge clk);
      if (acc_pop) begin
         void'(q.pop_front());
         if (preload_left > 0) preload_left--;
      end
      if (acc_push) q.push_back({msg, dat});
   endtask

   initial begin
      #(CLK_P * 150000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      for (int i = 0; i < NL; i++) q.push_back('0);
      preload_left = NL;
      // R1: reset state
      chk(cons_not_empty == 1'b1, "R1", "reset not_empty", cons_not_empty, 1);
      chk(prod_not_full == 1'b1, "R1", "reset not_full", prod_not_full, 1);
      chk(port_light == 1'b0, "R1", "reset light", port_light, 0);
      chk(port_heavy == 1'b0, "R1", "reset heavy", port_heavy, 0);

      // R2: drain the preload window
      for (int i = 0; i < NL; i++) step(0, 0, '0, 1);
      // R5: pops on empty are ignored
      for (int i = 0; i < 3; i++) step(0, 0, '0, 1);
      // R4: fill to capacity then push more
      for (int i = 0; i < CAP + 3; i++) step(1, 1, PW'(8'h10 + i), 0);
      // R3: drain in order
      for (int i = 0; i < CAP + 1; i++) step(0, 0, '0, 1);
      // R8: no-message tokens fill slots
      for (int i = 0; i < CAP; i++) step(1, 0, PW'(8'hA0 + i), 0);
      // R6: steady push+pop while full and at other levels
      for (int i = 0; i < 12; i++) step(1, i[0], PW'(8'h40 + i), 1);
      for (int i = 0; i < 4; i++) step(0, 0, '0, 1);
      for (int i = 0; i < 12; i++) step(1, 1, PW'(8'h60 + i), 1);
      // mixed random traffic
      for (int i = 0; i < 400; i++) begin
         logic [3:0] r = 4'($urandom);
         step(r[0] | r[3], r[1], PW'($urandom), r[2] | (r[3] & r[0]));
      end
      for (int i = 0; i < CAP + 2; i++) step(0, 0, '0, 1);
      @(negedge clk);
      compare();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule